// File: doc/BRIEF.md
# Packet-Marked Transmit Byte Queue

This block is the byte queue that feeds a bit-oriented frame transmitter from a microcontroller's register interface. Each stored word is a data byte plus an end-of-packet marker. The microcontroller has two write strobes that share one byte bus. One strobe writes an ordinary byte and the other writes the closing byte of a packet. Both land in the same 64-word storage, in write order, so several finished packets and one packet still being written can sit in the queue together.

The framer drains the queue through a valid/ready stream. `out_valid_o` is high whenever at least one word is stored, and `out_byte_o`/`out_eop_o` then show the oldest word. A word is consumed on a clock edge where `out_valid_o` and `out_ready_i` are both high. While `out_ready_i` is low the head word is held unchanged.

The write side has no ready signal. The writer is expected to consult `free_cnt_o`, and any write made while the queue is full is dropped and recorded in a sticky overflow flag. A drain-side interrupt is raised when a consumption leaves more free space than a programmable level. A flush input empties the whole queue in one cycle.

Top module: `pkt_tx_fifo`

## Requirements
- R1: After reset, `free_cnt_o` is 64, and `out_valid_o`, `thr_irq_o` and `ovf_o` are 0.
- R2: A write with `body_wr_i` alone stores the byte with marker 0. A write with `eop_wr_i` stores it with marker 1. If both strobes are high in one cycle, a single word is stored with marker 1. The marker appears on `out_eop_o` together with its byte.
- R3: Words leave in write order. While `out_valid_o` is 1 and `out_ready_i` is 0 (and no flush), the valid signal, byte and marker stay unchanged into the next cycle.
- R4: `free_cnt_o` equals 64 minus the number of stored words. It takes its new value in the cycle after the edge that accepted a write or consumed a word. An accepted write and a consumption on the same edge leave it unchanged.
- R5: A write whose edge sees `free_cnt_o` = 0 is discarded, even if a word is consumed on that edge. The queue contents stay the same, and `ovf_o` is 1 from the next cycle.
- R6: `ovf_o` stays 1 until a cycle with `ovf_ack_i` high. It reads 0 from the following cycle, unless a new discarded write happens on that same edge, in which case it stays 1.
- R7: `thr_irq_o` becomes 1 in the cycle after a consumption edge whose resulting free count is strictly greater than `thr_level_i`. Changing `thr_level_i` or writing never sets it.
- R8: `thr_irq_o` stays 1 until a cycle with `thr_ack_i` high. If a new setting consumption coincides with the acknowledge, the interrupt stays 1.
- R9: A cycle with `flush_i` high leaves the queue empty from the next cycle: free count 64 and `out_valid_o` 0. Writes in that cycle are dropped without setting `ovf_o`, and a handshake in that cycle does not set `thr_irq_o`.
- R10: Multiple packets stay resident. After writing two 9-byte packets and 2 bytes of a third, then consuming 4 bytes, the free count is 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| body_wr_i | input | 1 | Write strobe for a non-final packet byte |
| eop_wr_i | input | 1 | Write strobe for the final packet byte |
| wr_byte_i | input | 8 | Byte written by either strobe |
| out_valid_o | output | 1 | Queue holds at least one word |
| out_ready_i | input | 1 | Framer accepts the head word this cycle |
| out_byte_o | output | 8 | Head word data byte |
| out_eop_o | output | 1 | Head word end-of-packet marker |
| flush_i | input | 1 | Empty the whole queue |
| free_cnt_o | output | 7 | Number of free words |
| thr_level_i | input | 7 | Free-space level for the interrupt |
| thr_irq_o | output | 1 | Sticky free-space interrupt |
| thr_ack_i | input | 1 | Clears the interrupt |
| ovf_o | output | 1 | Sticky dropped-write flag |
| ovf_ack_i | input | 1 | Clears the overflow flag |

## Verification
The head word and `out_valid_o` are due one cycle after the edge that stored or consumed a word. `free_cnt_o`, `thr_irq_o` and `ovf_o` are also registered and are likewise due one edge after their cause. The bench drives each cycle's inputs just after a rising edge and updates its reference queue at the next edge. It compares every output one time unit after that edge, so each result is compared in the first cycle it is due and never across an edge. Directed sequences cover the corners: the full-queue write, coincident set and acknowledge, flush with a write, the dual strobe, and the multi-packet count.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              eop;
    logic [BYTE_W-1:0] data;
  } tx_word_t;
endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_ready,
  input  logic          flush,
  output logic          push,
  output logic          pop,
  output logic          wr_reject,
  output logic          rd_valid,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] used_q,
  output logic [CW-1:0] used_d
);
  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          full;
  logic [AW-1:0] wr_nxt;
  logic [AW-1:0] rd_nxt;

  assign full      = (used_q == FULL_CNT);
  assign rd_valid  = (used_q != '0);
  assign push      = wr_req & ~full & ~flush;
  assign pop       = rd_valid & rd_ready & ~flush;
  assign wr_reject = wr_req & full & ~flush;

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
    end
  endgenerate

  always_comb begin
    if (flush) begin
      used_d = '0;
    end else begin
      used_d = used_q;
      if (push && !pop) used_d = used_q + CW'(1);
      if (pop && !push) used_d = used_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used_q <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used_q <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      used_q <= used_d;
    end
  end

  // R4
  used_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= FULL_CNT);

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !flush && !rd_ready) |=> (used_q == FULL_CNT && $stable(wr_ptr)));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (used_q == '0 && !rd_valid));
endmodule

// File: rtl/pf_store.sv
module pf_store
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_ptr,
  input  tx_word_t      wdata,
  input  logic [AW-1:0] rd_ptr,
  output tx_word_t      rdata
);
  tx_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/pf_flags.sv
module pf_flags #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          wr_reject,
  input  logic [CW-1:0] free_nxt,
  input  logic [CW-1:0] thr_level,
  input  logic          thr_ack,
  input  logic          ovf_ack,
  output logic          thr_irq,
  output logic          ovf
);
  logic irq_set;

  assign irq_set = pop && (free_nxt > thr_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_irq <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      thr_irq <= irq_set | (thr_irq & ~thr_ack);
      ovf     <= wr_reject | (ovf & ~ovf_ack);
    end
  end

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_irq && !pop) |=> !thr_irq);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_irq && !thr_ack) |=> thr_irq);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_ack) |=> ovf);

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> ovf);
endmodule

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo
  import pkt_fifo_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              body_wr_i,
  input  logic              eop_wr_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              out_eop_o,
  input  logic              flush_i,
  output logic [CW-1:0]     free_cnt_o,
  input  logic [CW-1:0]     thr_level_i,
  output logic              thr_irq_o,
  input  logic              thr_ack_i,
  output logic              ovf_o,
  input  logic              ovf_ack_i
);
  logic          push, pop, wr_reject, wr_req;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] used_q, used_d, free_nxt;
  tx_word_t      wword, rword;

  assign wr_req     = body_wr_i | eop_wr_i;
  assign wword.eop  = eop_wr_i;
  assign wword.data = wr_byte_i;
  assign free_nxt   = CW'(DEPTH) - used_d;
  assign free_cnt_o = CW'(DEPTH) - used_q;
  assign out_byte_o = rword.data;
  assign out_eop_o  = rword.eop;

  pf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .wr_req   (wr_req),
    .rd_ready (out_ready_i),
    .flush    (flush_i),
    .push     (push),
    .pop      (pop),
    .wr_reject(wr_reject),
    .rd_valid (out_valid_o),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .used_q   (used_q),
    .used_d   (used_d)
  );

  pf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk_i),
    .we    (push),
    .wr_ptr(wr_ptr),
    .wdata (wword),
    .rd_ptr(rd_ptr),
    .rdata (rword)
  );

  pf_flags #(.CW(CW)) u_flags (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .pop      (pop),
    .wr_reject(wr_reject),
    .free_nxt (free_nxt),
    .thr_level(thr_level_i),
    .thr_ack  (thr_ack_i),
    .ovf_ack  (ovf_ack_i),
    .thr_irq  (thr_irq_o),
    .ovf      (ovf_o)
  );

  // R3
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !flush_i) |=>
      (out_valid_o && $stable(out_byte_o) && $stable(out_eop_o)));

  // R4
  free_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push && !pop && !flush_i) |=> $stable(free_cnt_o));
endmodule

// File: tb/test_pkt_tx_fifo.sv
module test_pkt_tx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int WDOG_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       body_wr = 0, eop_wr = 0, rdy = 0, flush = 0, tack = 0, oack = 0;
  logic [7:0] wbyte = '0;
  logic [6:0] thr = 7'd70;
  logic       valid, eop, irq, ovf;
  logic [7:0] obyte;
  logic [6:0] free_cnt;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  logic [8:0] q[$];
  logic m_irq = 0, m_ovf = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pkt_tx_fifo #(.DEPTH(DEPTH)) i_pkt_tx_fifo (
    .clk_i(clk), .rst_ni(rst_n), .body_wr_i(body_wr), .eop_wr_i(eop_wr),
    .wr_byte_i(wbyte), .out_valid_o(valid), .out_ready_i(rdy),
    .out_byte_o(obyte), .out_eop_o(eop), .flush_i(flush),
    .free_cnt_o(free_cnt), .thr_level_i(thr), .thr_irq_o(irq),
    .thr_ack_i(tack), .ovf_o(ovf), .ovf_ack_i(oack)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WDOG_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc_cnt, WDOG_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // Reference step: model the edge from the current inputs.
  function automatic void model_edge();
    bit pop, full, wr;
    pop  = (q.size() > 0) && rdy;
    full = (q.size() == DEPTH);
    wr   = body_wr | eop_wr;
    if (flush) begin
      q.delete();
      m_irq = m_irq & ~tack;
      m_ovf = m_ovf & ~oack;
    end else begin
      if (pop) void'(q.pop_front());
      if (wr && !full) q.push_back({eop_wr, wbyte});
      m_ovf = (wr && full) | (m_ovf & ~oack);
      m_irq = (pop && ((DEPTH - q.size()) > int'(thr))) | (m_irq & ~tack);
    end
  endfunction

  task automatic compare_all();
    chk("R4 free count", free_cnt, DEPTH - q.size());
    chk("R3 valid", valid, q.size() > 0);
    if (q.size() > 0) begin
      chk("R3 head byte", obyte, q[0][7:0]);
      chk("R2 head marker", eop, q[0][8]);
    end
    chk("R7 threshold irq", irq, m_irq);
    chk("R5 overflow flag", ovf, m_ovf);
  endtask

  task automatic cyc(bit bw, bit ew, logic [7:0] b, bit r, bit fl, bit ta, bit oa);
    body_wr = bw; eop_wr = ew; wbyte = b; rdy = r; flush = fl; tack = ta; oack = oa;
    model_edge();
    @(posedge clk);
    #1;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 free after reset", free_cnt, 64);
    chk("R1 valid after reset", valid, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 ovf after reset", ovf, 0);

    // R10: two 9-byte packets plus 2 bytes, then 4 consumed
    thr = 7'd100;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 8; i++) cyc(1, 0, 8'(p * 16 + i), 0, 0, 0, 0);
      cyc(0, 1, 8'(p * 16 + 8), 0, 0, 0, 0);
    end
    cyc(1, 0, 8'hA0, 0, 0, 0, 0);
    cyc(1, 0, 8'hA1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R10 free with resident packets", free_cnt, 48);

    // R2 both strobes in one cycle store one marked word
    cyc(1, 1, 8'h5C, 0, 0, 0, 0);
    chk("R2 dual strobe single word", free_cnt, 47);

    // R9 flush with a write in the same cycle
    cyc(1, 0, 8'h77, 1, 1, 0, 0);
    chk("R9 flush empties", free_cnt, 64);
    chk("R9 flush no valid", valid, 0);
    chk("R9 flush no ovf", ovf, 0);
    chk("R9 flush no irq", irq, 0);

    // R5 fill, then write when full while consuming
    for (int i = 0; i < DEPTH; i++) cyc(1, i[2], 8'(i), 0, 0, 0, 0);
    chk("R5 full", free_cnt, 0);
    cyc(1, 0, 8'hEE, 1, 0, 0, 0);
    chk("R5 dropped write sets ovf", ovf, 1);
    chk("R5 dropped write leaves count", free_cnt, 1);
    // R6 ack clears; ack with new drop keeps it
    cyc(1, 0, 8'hE1, 0, 0, 0, 0);
    chk("R6 refill", free_cnt, 0);
    cyc(1, 0, 8'hE2, 0, 0, 0, 1);
    chk("R6 ack with new drop stays set", ovf, 1);
    cyc(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R6 ack clears ovf", ovf, 0);

    // R7 lowering threshold alone does not raise irq
    thr = 7'd0;
    idle(3);
    chk("R7 threshold change no irq", irq, 0);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R7 consumption raises irq", irq, 1);
    // R8 sticky, coincident set wins, then clears
    idle(2);
    chk("R8 irq sticky", irq, 1);
    cyc(0, 0, 8'h00, 1, 0, 1, 0);
    chk("R8 set beats ack", irq, 1);
    cyc(0, 0, 8'h00, 0, 0, 1, 0);
    chk("R8 ack clears irq", irq, 0);
    // R7 strict greater-than boundary: free after pop equals level
    thr = 7'(free_cnt + 1);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R7 equal level no irq", irq, 0);
    cyc(0, 0, 8'h00, 1, 0, 0, 0);
    chk("R7 above level irq", irq, 1);
    cyc(0, 0, 8'h00, 0, 1, 1, 0);

    // Random phases against the reference queue
    for (int ph = 0; ph < 16; ph++) begin
      int wp, rp;
      wp = (ph % 4 == 0) ? 90 : (ph % 4 == 1) ? 20 : 55;
      rp = (ph % 4 == 0) ? 15 : (ph % 4 == 1) ? 90 : 50;
      thr = 7'($urandom_range(64));
      for (int i = 0; i < 250; i++) begin
        bit w, e;
        w = ($urandom_range(99) < wp);
        e = w && ($urandom_range(99) < 20);
        cyc(w && !e, e, 8'($urandom), $urandom_range(99) < rp,
            $urandom_range(999) < 4, $urandom_range(99) < 6,
            $urandom_range(99) < 6);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule